// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit RISC Word

This block is the execute step of a simple in-order integer pipeline. Each cycle it may accept one 32-bit fixed-length instruction word together with the two source operand values already read from the register file. It decodes the register-register and register-immediate layouts and builds the immediate operand. The immediate is sign-extended, zero-extended or moved into the upper half, depending on the operation. The block then computes the arithmetic, logic, compare or shift result, or the effective byte address of a word load or store.

The outcome is captured in one output register, so results appear one clock after the instruction is presented. Alongside the result the block reports the destination register index and a write-enable. It also reports a load or store request, a misaligned-address flag and an illegal-instruction flag. The register file, data memory, branch resolution and pipeline control live outside this block.

Top module: `rix_exec_unit`

## Requirements
- R1: While reset is asserted, and on leaving it, every output is zero.
- R2: An instruction accepted with `in_valid` high shows its outcome with `out_valid` high exactly one clock later. In a cycle after `in_valid` was low, `out_valid`, `wr_en`, `mem_rd`, `mem_wr`, `misaligned` and `illegal` are low, and `result` and `dest_idx` keep their previous values.
- R3: With opcode bits [31:26] equal to 0 and function code bits [5:0] of 32, 34, 36 or 37, the result is rs+rt, rs-rt, rs AND rt or rs OR rt. Here rs is `src_a` and rt is `src_b`. The destination is the rd field in bits [15:11].
- R4: Function code 42 (opcode 0) gives 1 when `src_a` is less than `src_b` as signed two's-complement values, and 0 otherwise. Opcode 10 does the same against the sign-extended immediate in bits [15:0].
- R5: Function code 0 shifts `src_b` left and function code 2 shifts it right, both by the amount in bits [10:6] with zero fill. `src_a` has no effect on either.
- R6: Opcode 8 adds `src_a` to the sign-extended immediate. Opcodes 12 and 13 AND and OR `src_a` with the zero-extended immediate. All register-immediate forms write the rt field in bits [20:16].
- R7: Opcode 15 returns the immediate in bits [31:16] with bits [15:0] zero, and `src_a` has no effect.
- R8: Opcodes 35 (load) and 43 (store) return `src_a` plus the sign-extended 16-bit offset as the result. A load raises `mem_rd` and writes rt. A store raises `mem_wr`, reports rt as `dest_idx` and keeps `wr_en` low.
- R9: `misaligned` is high exactly when a load or store address has a nonzero bit [1:0].
- R10: Any other opcode, or opcode 0 with any other function code, raises `illegal`. It gives a zero result, a zero `dest_idx`, and low `wr_en`, `mem_rd` and `mem_wr`.
- R11: `wr_en` is never high when the destination index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by bits [25:21] |
| src_b | input | 32 | Value of the register named by bits [20:16] |
| out_valid | output | 1 | Registered outcome is valid |
| result | output | 32 | Computed value or effective address |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write requested |
| mem_rd | output | 1 | Word load requested at `result` |
| mem_wr | output | 1 | Word store requested at `result` |
| misaligned | output | 1 | Load/store address not word aligned |
| illegal | output | 1 | Instruction not supported |

## Verification
The assertions assume that `in_valid` is held low throughout reset, so the first properties after reset look back only at an idle cycle. They also assume that `instr`, `src_a` and `src_b` are known whenever `in_valid` is high. The stimulus drives every input on the falling edge, keeps `in_valid` low for the whole reset, and drives defined values even in idle cycles. It inserts idle gaps between instructions to exercise the hold behaviour. It covers aligned and misaligned addresses, negative offsets, both immediate-extension kinds, and zero destinations.

// File: rtl/rix_pkg.sv
package rix_pkg;

    localparam int DATA_W      = 32;
    localparam int REG_IDX_W   = 5;
    localparam int IMM_W       = 16;
    localparam int SHAMT_W     = 5;
    localparam int OP_W        = 6;
    localparam int FN_W        = 6;
    localparam int ALIGN_BITS  = 2;
    localparam int OP_LSB      = DATA_W - OP_W;
    localparam int RD_LSB      = IMM_W - REG_IDX_W;
    localparam int SHAMT_LSB   = FN_W;
    localparam int LOW_W       = OP_LSB - REG_IDX_W;

    // Opcodes
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
    localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

    // Function codes for opcode 0
    localparam logic [FN_W-1:0] FN_SLL = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL = 6'd2;
    localparam logic [FN_W-1:0] FN_ADD = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB = 6'd34;
    localparam logic [FN_W-1:0] FN_AND = 6'd36;
    localparam logic [FN_W-1:0] FN_OR  = 6'd37;
    localparam logic [FN_W-1:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG, OPB_SEXT, OPB_ZEXT
    } opb_sel_e;

    typedef enum logic [1:0] {
        RES_ALU, RES_ADDR, RES_NONE
    } res_sel_e;

    typedef struct packed {
        alu_op_e                alu_op;
        opb_sel_e               opb_sel;
        res_sel_e               res_sel;
        logic [REG_IDX_W-1:0]   dest;
        logic                   wr;
        logic                   mem_rd;
        logic                   mem_wr;
        logic                   illegal;
    } dec_t;

    typedef struct packed {
        logic                   valid;
        logic [DATA_W-1:0]      result;
        logic [REG_IDX_W-1:0]   dest;
        logic                   wr_en;
        logic                   mem_rd;
        logic                   mem_wr;
        logic                   misaligned;
        logic                   illegal;
    } stage_t;

endpackage

// File: rtl/rix_decoder.sv
module rix_decoder
    import rix_pkg::*;
(
    input  logic [OP_W-1:0]       opcode,
    input  logic [LOW_W-1:0]      low_bits,
    output dec_t                  dec,
    output logic [DATA_W-1:0]     imm_sext,
    output logic [DATA_W-1:0]     imm_zext
);

    logic [FN_W-1:0]      funct;
    logic [REG_IDX_W-1:0] rd_idx;
    logic [REG_IDX_W-1:0] rt_idx;
    logic [IMM_W-1:0]     imm;

    assign funct  = low_bits[FN_W-1:0];
    assign rd_idx = low_bits[RD_LSB +: REG_IDX_W];
    assign rt_idx = low_bits[IMM_W +: REG_IDX_W];
    assign imm    = low_bits[IMM_W-1:0];

    assign imm_sext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_zext = {{(DATA_W-IMM_W){1'b0}}, imm};

    always_comb begin
        dec.alu_op  = ALU_ADD;
        dec.opb_sel = OPB_REG;
        dec.res_sel = RES_NONE;
        dec.dest    = '0;
        dec.wr      = 1'b0;
        dec.mem_rd  = 1'b0;
        dec.mem_wr  = 1'b0;
        dec.illegal = 1'b1;

        unique case (opcode)
            OPC_RTYPE: begin
                dec.illegal = 1'b0;
                dec.res_sel = RES_ALU;
                dec.dest    = rd_idx;
                dec.wr      = 1'b1;
                unique case (funct)
                    FN_ADD:  dec.alu_op = ALU_ADD;
                    FN_SUB:  dec.alu_op = ALU_SUB;
                    FN_AND:  dec.alu_op = ALU_AND;
                    FN_OR:   dec.alu_op = ALU_OR;
                    FN_SLT:  dec.alu_op = ALU_SLT;
                    FN_SLL:  dec.alu_op = ALU_SLL;
                    FN_SRL:  dec.alu_op = ALU_SRL;
                    default: begin
                        dec.illegal = 1'b1;
                        dec.res_sel = RES_NONE;
                        dec.dest    = '0;
                        dec.wr      = 1'b0;
                    end
                endcase
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LUI: begin
                dec.illegal = 1'b0;
                dec.res_sel = RES_ALU;
                dec.dest    = rt_idx;
                dec.wr      = 1'b1;
                unique case (opcode)
                    OPC_ADDI: begin dec.alu_op = ALU_ADD; dec.opb_sel = OPB_SEXT; end
                    OPC_SLTI: begin dec.alu_op = ALU_SLT; dec.opb_sel = OPB_SEXT; end
                    OPC_ANDI: begin dec.alu_op = ALU_AND; dec.opb_sel = OPB_ZEXT; end
                    OPC_ORI:  begin dec.alu_op = ALU_OR;  dec.opb_sel = OPB_ZEXT; end
                    default:  begin dec.alu_op = ALU_LUI; dec.opb_sel = OPB_ZEXT; end
                endcase
            end
            OPC_LW: begin
                dec.illegal = 1'b0;
                dec.res_sel = RES_ADDR;
                dec.dest    = rt_idx;
                dec.wr      = 1'b1;
                dec.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                dec.illegal = 1'b0;
                dec.res_sel = RES_ADDR;
                dec.dest    = rt_idx;
                dec.mem_wr  = 1'b1;
            end
            default: ;
        endcase

        // Register 0 is never written
        if (dec.dest == '0) begin
            dec.wr = 1'b0;
        end
    end

endmodule

// File: rtl/rix_alu.sv
module rix_alu
    import rix_pkg::*;
(
    input  alu_op_e               op,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [SHAMT_W-1:0]    shamt,
    output logic [DATA_W-1:0]     y
);

    logic signed [DATA_W-1:0] sa;
    logic signed [DATA_W-1:0] sb;

    assign sa = opnd_a;
    assign sb = opnd_b;

    always_comb begin
        unique case (op)
            ALU_ADD: y = opnd_a + opnd_b;
            ALU_SUB: y = opnd_a - opnd_b;
            ALU_AND: y = opnd_a & opnd_b;
            ALU_OR:  y = opnd_a | opnd_b;
            ALU_SLT: y = {{(DATA_W-1){1'b0}}, (sa < sb)};
            ALU_SLL: y = opnd_b << shamt;
            ALU_SRL: y = opnd_b >> shamt;
            default: y = {opnd_b[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}};
        endcase
    end

endmodule

// File: rtl/rix_agu.sv
module rix_agu
    import rix_pkg::*;
(
    input  logic [DATA_W-1:0]     base,
    input  logic [DATA_W-1:0]     offset,
    output logic [DATA_W-1:0]     addr,
    output logic                  unaligned
);

    assign addr      = base + offset;
    assign unaligned = |addr[ALIGN_BITS-1:0];

endmodule

// File: rtl/rix_exec_unit.sv
module rix_exec_unit
    import rix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     instr,
    input  logic [DATA_W-1:0]     src_a,
    input  logic [DATA_W-1:0]     src_b,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     result,
    output logic [REG_IDX_W-1:0]  dest_idx,
    output logic                  wr_en,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic                  misaligned,
    output logic                  illegal
);

    dec_t                 dec;
    logic [DATA_W-1:0]    imm_sext;
    logic [DATA_W-1:0]    imm_zext;
    logic [DATA_W-1:0]    opnd_b;
    logic [DATA_W-1:0]    alu_y;
    logic [DATA_W-1:0]    ea;
    logic                 ea_unaligned;
    logic                 unused_rs_field;
    stage_t               st_d;
    stage_t               st_q;

    // The source index field only selects the register read outside this block
    assign unused_rs_field = ^instr[OP_LSB-1 -: REG_IDX_W];

    rix_decoder u_dec (
        .opcode   (instr[DATA_W-1 -: OP_W]),
        .low_bits (instr[LOW_W-1:0]),
        .dec      (dec),
        .imm_sext (imm_sext),
        .imm_zext (imm_zext)
    );

    always_comb begin
        unique case (dec.opb_sel)
            OPB_SEXT: opnd_b = imm_sext;
            OPB_ZEXT: opnd_b = imm_zext;
            default:  opnd_b = src_b;
        endcase
    end

    rix_alu u_alu (
        .op     (dec.alu_op),
        .opnd_a (src_a),
        .opnd_b (opnd_b),
        .shamt  (instr[SHAMT_LSB +: SHAMT_W]),
        .y      (alu_y)
    );

    rix_agu u_agu (
        .base      (src_a),
        .offset    (imm_sext),
        .addr      (ea),
        .unaligned (ea_unaligned)
    );

    always_comb begin
        st_d            = st_q;
        st_d.valid      = in_valid;
        st_d.wr_en      = 1'b0;
        st_d.mem_rd     = 1'b0;
        st_d.mem_wr     = 1'b0;
        st_d.misaligned = 1'b0;
        st_d.illegal    = 1'b0;
        if (in_valid) begin
            unique case (dec.res_sel)
                RES_ALU:  st_d.result = alu_y;
                RES_ADDR: st_d.result = ea;
                default:  st_d.result = '0;
            endcase
            st_d.dest       = dec.dest;
            st_d.wr_en      = dec.wr;
            st_d.mem_rd     = dec.mem_rd;
            st_d.mem_wr     = dec.mem_wr;
            st_d.misaligned = (dec.mem_rd | dec.mem_wr) & ea_unaligned;
            st_d.illegal    = dec.illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign result     = st_q.result;
    assign dest_idx   = st_q.dest;
    assign wr_en      = st_q.wr_en;
    assign mem_rd     = st_q.mem_rd;
    assign mem_wr     = st_q.mem_wr;
    assign misaligned = st_q.misaligned;
    assign illegal    = st_q.illegal;

endmodule

// File: rtl/rix_exec_checker.sv
module rix_exec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  dest_idx,
    input logic        wr_en,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        misaligned,
    input logic        illegal
);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !mem_rd && !mem_wr && !misaligned && !illegal));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(dest_idx)));

    assert_lui_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && instr[31:26] == 6'd15) |-> (result[15:0] == 16'h0));

    assert_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && instr[31:26] == 6'd43) |-> (mem_wr && !mem_rd && !wr_en));

    assert_mem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> ((mem_rd || mem_wr) && result[1:0] != 2'b00));

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !mem_rd && !mem_wr && result == 32'h0 && dest_idx == 5'd0));

    assert_no_zero_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dest_idx != 5'd0));

endmodule

bind rix_exec_unit rix_exec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .instr      (instr),
    .out_valid  (out_valid),
    .result     (result),
    .dest_idx   (dest_idx),
    .wr_en      (wr_en),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .misaligned (misaligned),
    .illegal    (illegal)
);

// File: tb/rix_exec_unit_tb.sv
module rix_exec_unit_tb;

    typedef struct {
        logic        valid;
        logic [31:0] result;
        logic [4:0]  dest;
        logic        wr;
        logic        mrd;
        logic        mwr;
        logic        mis;
        logic        ill;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        mem_rd;
    logic        mem_wr;
    logic        misaligned;
    logic        illegal;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q;
    string exp_tag;
    bit   pend = 0;

    always #4 clk = ~clk;

    rix_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
        .dest_idx(dest_idx), .wr_en(wr_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .misaligned(misaligned), .illegal(illegal)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        enc_r = {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        enc_i = {op[5:0], rs[4:0], rt[4:0], imm};
    endfunction

    // Behavioural reference derived from the requirements
    function automatic exp_t model(logic v, logic [31:0] ins, logic [31:0] a,
                                   logic [31:0] b, exp_t prev);
        exp_t e;
        int op, fn, sh;
        logic [31:0] sx, zx;
        logic [4:0] rt, rd;
        e = prev;
        e.valid = v; e.wr = 0; e.mrd = 0; e.mwr = 0; e.mis = 0; e.ill = 0;
        if (!v) return e;
        op = int'(ins[31:26]); fn = int'(ins[5:0]); sh = int'(ins[10:6]);
        rt = ins[20:16]; rd = ins[15:11];
        sx = 32'(signed'(ins[15:0]));
        zx = {16'h0, ins[15:0]};
        e.dest = rt;
        if (op == 0) begin
            e.dest = rd;
            case (fn)
                32: e.result = a + b;
                34: e.result = a - b;
                36: e.result = a & b;
                37: e.result = a | b;
                42: e.result = (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
                0:  e.result = b << sh;
                2:  e.result = b >> sh;
                default: e.ill = 1;
            endcase
            e.wr = !e.ill;
        end else if (op == 8)  begin e.result = a + sx; e.wr = 1; end
        else if (op == 10) begin e.result = (signed'(a) < signed'(sx)) ? 32'd1 : 32'd0; e.wr = 1; end
        else if (op == 12) begin e.result = a & zx; e.wr = 1; end
        else if (op == 13) begin e.result = a | zx; e.wr = 1; end
        else if (op == 15) begin e.result = {ins[15:0], 16'h0}; e.wr = 1; end
        else if (op == 35) begin e.result = a + sx; e.mrd = 1; e.wr = 1; e.mis = (e.result % 4) != 0; end
        else if (op == 43) begin e.result = a + sx; e.mwr = 1; e.mis = (e.result % 4) != 0; end
        else e.ill = 1;
        if (e.ill) begin e.result = 0; e.dest = 0; e.wr = 0; end
        if (e.dest == 0) e.wr = 0;
        return e;
    endfunction

    task automatic compare(exp_t e, string tag);
        n_checks++;
        if (out_valid !== e.valid || result !== e.result || dest_idx !== e.dest ||
            wr_en !== e.wr || mem_rd !== e.mrd || mem_wr !== e.mwr ||
            misaligned !== e.mis || illegal !== e.ill) begin
            n_fail++;
            $display("FAIL %s: got v=%0b res=%h dst=%0d we=%0b rd=%0b wr=%0b mis=%0b ill=%0b, expected v=%0b res=%h dst=%0d we=%0b rd=%0b wr=%0b mis=%0b ill=%0b",
                     tag, out_valid, result, dest_idx, wr_en, mem_rd, mem_wr, misaligned, illegal,
                     e.valid, e.result, e.dest, e.wr, e.mrd, e.mwr, e.mis, e.ill);
        end
    endtask

    task automatic step(logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        if (pend) compare(exp_q, exp_tag);
        exp_q = model(v, ins, a, b, exp_q);
        exp_tag = tag;
        pend = 1;
        in_valid = v; instr = ins; src_a = a; src_b = b;
    endtask

    initial begin
        exp_t zero_e;
        zero_e = '{valid:0, result:0, dest:0, wr:0, mrd:0, mwr:0, mis:0, ill:0};
        exp_q = zero_e;
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        compare(zero_e, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(zero_e, "R1 after reset");

        // R3 register-register arithmetic and logic
        step(1, enc_r(1, 2, 3, 0, 32), 32'h7fff_ffff, 32'h0000_0001, "R3 add");
        step(1, enc_r(4, 5, 6, 0, 34), 32'h0000_0005, 32'h0000_0009, "R3 sub");
        step(1, enc_r(7, 8, 9, 0, 36), 32'hf0f0_1234, 32'h0ff0_ffff, "R3 and");
        step(1, enc_r(7, 8, 31, 0, 37), 32'hf000_0000, 32'h0000_000f, "R3 or");
        // R2 idle gap: hold
        step(0, enc_r(1, 2, 3, 0, 32), 32'h1111_1111, 32'h2222_2222, "R2 idle");
        step(0, 32'hffff_ffff, 32'h0, 32'h0, "R2 idle2");
        // R4 signed compare
        step(1, enc_r(1, 2, 10, 0, 42), 32'hffff_fffe, 32'h0000_0001, "R4 slt neg<pos");
        step(1, enc_r(1, 2, 10, 0, 42), 32'h0000_0001, 32'hffff_fffe, "R4 slt pos<neg");
        step(1, enc_r(1, 2, 10, 0, 42), 32'h0000_0003, 32'h0000_0003, "R4 slt equal");
        step(1, enc_i(10, 1, 11, 16'hfff0), 32'hffff_ff00, 32'h0, "R4 slti neg imm");
        step(1, enc_i(10, 1, 11, 16'h8000), 32'h0000_0000, 32'h0, "R4 slti min imm");
        // R5 shifts, src_a ignored
        step(1, enc_r(9, 2, 12, 8, 0), 32'hdead_beef, 32'h0000_00ff, "R5 sll 8");
        step(1, enc_r(9, 2, 12, 31, 0), 32'h1234_5678, 32'h0000_0003, "R5 sll 31");
        step(1, enc_r(9, 2, 13, 4, 2), 32'hffff_ffff, 32'hf000_0000, "R5 srl 4 zero fill");
        step(1, enc_r(0, 2, 13, 0, 2), 32'h0, 32'h8765_4321, "R5 srl 0");
        // R6 immediates
        step(1, enc_i(8, 1, 14, 16'hffff), 32'h0000_0010, 32'h5555_5555, "R6 addi sext");
        step(1, enc_i(12, 1, 15, 16'h8001), 32'hffff_ffff, 32'h0, "R6 andi zext");
        step(1, enc_i(13, 1, 16, 16'h8000), 32'h0000_0001, 32'h0, "R6 ori zext");
        // R7 load-upper, src_a ignored
        step(1, enc_i(15, 3, 17, 16'hbeef), 32'hffff_ffff, 32'h0, "R7 lui");
        // R8 / R9 loads and stores
        step(1, enc_i(35, 2, 18, 16'h0008), 32'h0000_0010, 32'h0, "R8 lw aligned");
        step(1, enc_i(35, 2, 18, 16'hfffe), 32'h0000_0100, 32'h0, "R9 lw misaligned neg");
        step(1, enc_i(43, 2, 19, 16'h000c), 32'h0000_0008, 32'h69, "R8 sw aligned");
        step(1, enc_i(43, 2, 19, 16'h0001), 32'h0000_0008, 32'h69, "R9 sw misaligned");
        step(1, enc_i(35, 2, 0, 16'h7fff), 32'h0000_0001, 32'h0, "R11 lw to reg0");
        // R10 illegal encodings
        step(1, enc_r(1, 2, 3, 0, 3), 32'h1, 32'h2, "R10 bad funct");
        step(1, enc_i(4, 1, 2, 16'h0003), 32'h1, 32'h1, "R10 branch op");
        step(1, enc_i(63, 1, 2, 16'h0003), 32'h1, 32'h1, "R10 op 63");
        // R11 writes to register 0
        step(1, enc_r(1, 2, 0, 0, 32), 32'h1, 32'h2, "R11 add to reg0");
        step(1, enc_i(8, 1, 0, 16'h0004), 32'h1, 32'h2, "R11 addi to reg0");
        // R2 back to back then idle
        step(1, enc_i(13, 0, 5, 16'h029a), 32'h0, 32'h0, "R2 ori burst");
        step(0, 32'h0, 32'h0, 32'h0, "R2 idle after burst");
        step(0, 32'h0, 32'h0, 32'h0, "R2 flush");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule